// File: doc/BRIEF.md
# Flat-XOR Column Mixer

This block applies the AES column-mixing step to one 32-bit state column. The column holds four bytes, E0 to E3, and the block returns four mixed bytes, S0 to S3. Each output byte is a sum over GF(2^8) of the four input bytes, weighted by the constants {02}, {03}, {01} and {01}. Output row r uses that row of weights rotated right by r positions.

Every one of the 32 output bits is a single flat XOR of the input bits it depends on. There are no chained multiply-by-constant stages. The tap sets are computed at elaboration time from the field arithmetic, so each bit is one shallow parity tree that fits one or two small lookup primitives.

A column is accepted on any clock where `in_valid` is high. The mixed column is registered and appears one clock later with `out_valid`. A new column can be accepted every clock.

Top module: `mixcol_flat`

## Requirements
- R1: While `rst` is high at a clock edge, the output register clears: `out_valid` is 0 and `out_col` is 0 on the following cycle.
- R2: `out_valid` is high on exactly the cycle after a cycle in which `in_valid` was high at the clock edge.
- R3: For an accepted column, the outputs are S0 = 2·E0⊕3·E1⊕E2⊕E3, S1 = E0⊕2·E1⊕3·E2⊕E3, S2 = E0⊕E1⊕2·E2⊕3·E3 and S3 = 3·E0⊕E1⊕E2⊕2·E3 over GF(2^8). Here 3·x = 2·x ⊕ x.
- R4: Doubling reduces by the polynomial x^8+x^4+x^3+x+1. The byte is shifted left by one, then XORed with 0x1B if its top bit was 1. For example, column 0x80000000 maps to 0x1B80809B.
- R5: Byte packing: E0 is `in_col[31:24]` and E3 is `in_col[7:0]`, with the same layout for S0..S3 on `out_col`. Bit 0 of each byte is its least significant bit.
- R6: S0 bit 0 equals E0(7)⊕E1(0)⊕E1(7)⊕E2(0)⊕E3(0).
- R7: S0 bit 1 equals E0(0)⊕E0(7)⊕E1(0)⊕E1(1)⊕E1(7)⊕E2(1)⊕E3(1). This is one of the seven-input bits.
- R8: On a cycle where `in_valid` is low, the input data is ignored. `out_col` keeps its previous value and `out_valid` goes low.
- R9: Columns presented on consecutive clocks each produce their own result on consecutive clocks, with no bubble.
- R10: The XOR of the four output bytes equals the XOR of the four input bytes of the same column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input column strobe |
| in_col | input | 32 | Input column, E0 in the top byte |
| out_valid | output | 1 | Result strobe, one clock after the input |
| out_col | output | 32 | Mixed column, S0 in the top byte |

## Verification
The bench targets columns whose bytes have the top bit set, including the all-0xFF column. A design that dropped the 0x1B reduction term, or folded it into the wrong bit, would miscompute the seven-input bits 1, 3 and 4. The single-byte column 0x80000000 and the known column vectors show a swapped byte order or an unrotated weight row as a wrong lane. Idle cycles carrying junk data catch a register that loads without the strobe. Long back-to-back streams catch a result that is delayed, or merged with its neighbour.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
  localparam int BYTE_W = 8;
  localparam int ROWS   = 4;
  localparam int COL_W  = BYTE_W * ROWS;

  // Doubling in GF(2^8) with the 0x11B reduction.
  function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] b);
    return {b[BYTE_W-2:0], 1'b0} ^ (b[BYTE_W-1] ? 8'h1b : 8'h00);
  endfunction

  // Multiply by one of the small weights 1, 2 or 3.
  function automatic logic [BYTE_W-1:0] gf_weight(input logic [BYTE_W-1:0] b, input int w);
    logic [BYTE_W-1:0] r;
    case (w)
      2:       r = gf_dbl(b);
      3:       r = gf_dbl(b) ^ b;
      default: r = b;
    endcase
    return r;
  endfunction

  // Weight of input byte c in output row r: base row {2,3,1,1} rotated right by r.
  function automatic int row_weight(input int r, input int c);
    int k;
    k = (c - r + ROWS) % ROWS;
    case (k)
      0:       return 2;
      1:       return 3;
      default: return 1;
    endcase
  endfunction

  // Output byte r of a column, E0 packed in the top byte.
  function automatic logic [BYTE_W-1:0] mix_row(input logic [COL_W-1:0] col, input int r);
    logic [BYTE_W-1:0] acc;
    acc = '0;
    for (int c = 0; c < ROWS; c++) begin
      acc ^= gf_weight(col[COL_W-1-BYTE_W*c -: BYTE_W], row_weight(r, c));
    end
    return acc;
  endfunction

  // Set of input bits feeding output bit (r, b): found by probing each unit vector.
  function automatic logic [COL_W-1:0] tap_mask(input int r, input int b);
    logic [COL_W-1:0] m;
    logic [BYTE_W-1:0] y;
    m = '0;
    for (int i = 0; i < COL_W; i++) begin
      y = mix_row(COL_W'(1) << i, r);
      m[i] = y[b];
    end
    return m;
  endfunction
endpackage

// File: rtl/mixcol_byte_lane.sv
module mixcol_byte_lane
  import mixcol_pkg::*;
#(
  parameter int ROW = 0
) (
  input  logic [COL_W-1:0]  col,
  output logic [BYTE_W-1:0] lane
);
  // One flat parity tree per output bit; no chained multiplier stages.
  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    localparam logic [COL_W-1:0] TAPS = tap_mask(ROW, b);
    assign lane[b] = ^(col & TAPS);
  end
endmodule

// File: rtl/mixcol_out_reg.sv
module mixcol_out_reg
  import mixcol_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [COL_W-1:0] d,
  output logic             vq,
  output logic [COL_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vq <= 1'b0;
      q  <= '0;
    end else begin
      vq <= load;
      if (load) q <= d;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!vq && q == '0));

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    vq == $past(load));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |-> $stable(q));
endmodule

// File: rtl/mixcol_flat.sv
module mixcol_flat
  import mixcol_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [COL_W-1:0] in_col,
  output logic             out_valid,
  output logic [COL_W-1:0] out_col
);
  logic [COL_W-1:0] mixed;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    mixcol_byte_lane #(.ROW(r)) u_lane (
      .col  (in_col),
      .lane (mixed[COL_W-1-BYTE_W*r -: BYTE_W])
    );
  end

  mixcol_out_reg u_reg (
    .clk  (clk),
    .rst  (rst),
    .load (in_valid),
    .d    (mixed),
    .vq   (out_valid),
    .q    (out_col)
  );

  // Byte-sum views used by the parity-conservation check.
  logic [BYTE_W-1:0] in_sum, out_sum;
  assign in_sum  = in_col[31:24] ^ in_col[23:16] ^ in_col[15:8] ^ in_col[7:0];
  assign out_sum = out_col[31:24] ^ out_col[23:16] ^ out_col[15:8] ^ out_col[7:0];

  assert_s0_bit0_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(rst)) |-> out_col[24] ==
      ($past(in_col[31]) ^ $past(in_col[16]) ^ $past(in_col[23]) ^ $past(in_col[8]) ^ $past(in_col[0])));

  assert_s0_bit1_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(rst)) |-> out_col[25] ==
      ($past(in_col[24]) ^ $past(in_col[31]) ^ $past(in_col[16]) ^ $past(in_col[17]) ^
       $past(in_col[23]) ^ $past(in_col[9]) ^ $past(in_col[1])));

  assert_byte_sum_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(rst)) |-> out_sum == $past(in_sum));
endmodule

// File: tb/mixcol_flat_bench.sv
module mixcol_flat_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_col = '0;
  logic        out_valid;
  logic [31:0] out_col;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mixcol_flat u_mixcol_flat (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_col(in_col),
    .out_valid(out_valid), .out_col(out_col)
  );

  function automatic logic [7:0] x2(input logic [7:0] v);
    logic [7:0] s;
    s = v << 1;
    if (v[7]) s = s ^ 8'h1b;
    return s;
  endfunction

  function automatic logic [7:0] x3(input logic [7:0] v);
    return x2(v) ^ v;
  endfunction

  function automatic logic [31:0] expect_col(input logic [31:0] c);
    logic [7:0] a, b, e, f;
    a = c[31:24]; b = c[23:16]; e = c[15:8]; f = c[7:0];
    return {x2(a) ^ x3(b) ^ e ^ f,
            a ^ x2(b) ^ x3(e) ^ f,
            a ^ b ^ x2(e) ^ x3(f),
            x3(a) ^ b ^ e ^ x2(f)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present one column, then check it at the next falling edge.
  task automatic send(input string tag, input logic [31:0] c);
    in_valid = 1'b1;
    in_col   = c;
    @(negedge clk);
    check({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    check(tag, out_col, expect_col(c));
  endtask

  initial begin
    logic [31:0] held;
    logic [31:0] c;
    logic [7:0]  s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'b0, out_valid}, 32'd0);
    check("R1 reset data", out_col, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 no input no valid", {31'b0, out_valid}, 32'd0);

    send("R3 vector db135345", 32'hdb135345);
    check("R3 known result", out_col, 32'h8e4da1bc);
    send("R3 vector f20a225c", 32'hf20a225c);
    check("R3 known result2", out_col, 32'h9fdc589d);
    send("R4 top-bit reduction", 32'h80000000);
    check("R4 0x1b fold", out_col, 32'h1b80809b);
    send("R5 low byte only", 32'h00000001);
    check("R5 byte order", out_col, 32'h01010302);
    send("R3 all zero", 32'h00000000);
    send("R3 all ff", 32'hffffffff);
    check("R3 all ff value", out_col, 32'hffffffff);

    // R6 / R7: single-bit probes of the named bit equations.
    for (int i = 0; i < 32; i++) begin
      send("R6 R7 unit probe", 32'h1 << i);
      check("R6 s0 bit0", {31'b0, out_col[24]},
            {31'b0, (i == 31) | (i == 16) | (i == 23) | (i == 8) | (i == 0)});
      check("R7 s0 bit1", {31'b0, out_col[25]},
            {31'b0, (i == 24) | (i == 31) | (i == 16) | (i == 17) | (i == 23) | (i == 9) | (i == 1)});
    end

    // R8: idle cycles with junk data.
    held = out_col;
    in_valid = 1'b0;
    in_col   = 32'hdeadbeef;
    @(negedge clk);
    check("R8 idle valid low", {31'b0, out_valid}, 32'd0);
    check("R8 idle data held", out_col, held);
    in_col = 32'h12345678;
    @(negedge clk);
    check("R8 idle data held2", out_col, held);

    // R9 / R10: random back-to-back stream.
    for (int n = 0; n < 300; n++) begin
      c = $urandom();
      if (n % 17 == 0) c = c | 32'h80808080;
      send("R9 stream", c);
      s = out_col[31:24] ^ out_col[23:16] ^ out_col[15:8] ^ out_col[7:0];
      check("R10 byte sum", {24'b0, s}, {24'b0, c[31:24] ^ c[23:16] ^ c[15:8] ^ c[7:0]});
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 valid drops", {31'b0, out_valid}, 32'd0);

    // R1: reset mid-run.
    send("R3 before reset", 32'h01020304);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears valid", {31'b0, out_valid}, 32'd0);
    check("R1 reset clears data", out_col, 32'd0);
    rst = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule